// File: doc/BRIEF.md
# Staged Clock Divider Ratio Bank

This block holds the divide ratios for a set of clock-enable dividers that feed a display pipeline with two output channels, a main one and an auxiliary one. Each channel owns seven dividers, and each divider ratio is a 3-bit field. Software reaches the fields through a small word-wide register port. The two channels place their fields at different bit positions inside the same two staging words.

Software reprograms the dividers in three steps:

1. It clears the update flag.
2. It writes any number of new fields.
3. It sets the flag again.

The flag's transition from clear to set copies every staged field into the live ratios at one clock edge. A reprogram that touches several fields therefore takes effect as a whole. Each live ratio drives a counter that emits a one-cycle enable strobe on a fixed cadence of the source clock. Consumers use that strobe as a clock enable.

The read port is combinational. Two addresses return the staged words and two addresses return the live ratios, so software can tell what is pending from what is in force.

Top module: `cdiv_bank`

## Requirements
- R1: After reset, every staged field, the update flag and every live ratio read as zero, and every strobe output is high continuously (ratio 0).
- R2: Field layout. Divider k of channel c (c=0 main, c=1 auxiliary, k in 0..6) drives `div_strobe[7*c+k]`. For k<2 the field sits in word 0 at bits [3*(2c+k)+2 : 3*(2c+k)]. For k>=2 it sits in word 1 at bits [3*(5c+k-2)+2 : 3*(5c+k-2)]. The update flag is bit 31 of word 1.
- R3: Reading address 0 returns the staged word 0. Reading address 1 returns the staged word 1 with the flag at bit 31. Every bit that holds no field reads as zero.
- R4: A write that does not take the flag from clear to set changes no live ratio and no strobe cadence.
- R5: A write to address 1 with bit 31 set, while the staged flag is clear, copies all staged fields into the live ratios at that clock edge. The copied fields include the ones carried by that same write.
- R6: A write to address 1 with bit 31 set while the flag is already set updates the staged fields only.
- R7: A write to address 1 with bit 31 clear stages fields and clears the flag, without a commit.
- R8: Reading address 2 returns the live values in the word 0 layout. Reading address 3 returns the live values in the word 1 layout, with bit 31 reading 0.
- R9: A divider with live ratio N raises its strobe for one cycle out of every N+1 source cycles. Ratio 0 keeps the strobe high.
- R10: When a commit changes a divider's ratio to N, its counter restarts. The strobe is low for the first N cycles after the commit edge and high in cycle N, counting from 0.
- R11: A commit that leaves a divider's ratio unchanged does not disturb that divider's strobe phase.
- R12: Writes to addresses 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Write address (0 and 1 are writable) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Combinational read data |
| div_strobe | output | 14 | Per-divider clock-enable strobes, index 7*channel+divider |

## Verification
Read data is combinational, so it is due in the same cycle that the address is presented. Staged words change at the write edge. Live ratios and strobe restarts also land at the write edge that commits, so both are visible in the cycle that follows it. A restarted divider's first strobe is due N cycles after that commit edge.

The bench drives every input on the falling edge and advances its model at the rising edge. It compares strobes and read data on the next falling edge. The model predicts each strobe from the number of cycles since that divider's last restart, taken modulo N+1.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int DIV_W      = 3;
  localparam int NUM_CH     = 2;
  localparam int SEL_PER_CH = 2;
  localparam int PAR_PER_CH = 5;
  localparam int DIV_PER_CH = SEL_PER_CH + PAR_PER_CH;
  localparam int NUM_DIV    = NUM_CH * DIV_PER_CH;
  localparam int SEL_BITS   = NUM_CH * SEL_PER_CH * DIV_W;
  localparam int PAR_BITS   = NUM_CH * PAR_PER_CH * DIV_W;
  localparam int REG_W      = 32;
  localparam int FLAG_BIT   = REG_W - 1;
  localparam int ADDR_W     = 2;

  typedef enum logic [ADDR_W-1:0] {
    AD_SEL_STAGE = 2'd0,
    AD_PAR_STAGE = 2'd1,
    AD_SEL_LIVE  = 2'd2,
    AD_PAR_LIVE  = 2'd3
  } cdiv_addr_e;

  // true when divider k of a channel lives in the select word
  function automatic bit in_sel_word(input int k);
    return k < SEL_PER_CH;
  endfunction

  // field slot index inside its word for divider k of channel ch
  function automatic int slot_of(input int ch, input int k);
    if (in_sel_word(k)) return ch * SEL_PER_CH + k;
    return ch * PAR_PER_CH + (k - SEL_PER_CH);
  endfunction

  // a strobe is due when the phase counter reaches the ratio
  function automatic logic strobe_due(input logic [DIV_W-1:0] cnt,
                                      input logic [DIV_W-1:0] ratio);
    return cnt == ratio;
  endfunction

  // pack a divider word for the read port
  function automatic logic [REG_W-1:0] pack_par(input logic [PAR_BITS-1:0] f,
                                                input logic flag);
    logic [REG_W-1:0] r;
    r = '0;
    r[PAR_BITS-1:0] = f;
    r[FLAG_BIT] = flag;
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_sel(input logic [SEL_BITS-1:0] f);
    logic [REG_W-1:0] r;
    r = '0;
    r[SEL_BITS-1:0] = f;
    return r;
  endfunction

endpackage

// File: rtl/cdiv_stage_regs.sv
module cdiv_stage_regs
  import cdiv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  output logic [SEL_BITS-1:0] sel_stage,
  output logic [PAR_BITS-1:0] par_stage,
  output logic                flag_stage,
  output logic [SEL_BITS-1:0] sel_next,
  output logic [PAR_BITS-1:0] par_next,
  output logic                commit
);

  logic wr_sel, wr_par, flag_next;
  logic unused_pad;

  assign wr_sel = wr_en && (wr_addr == AD_SEL_STAGE);
  assign wr_par = wr_en && (wr_addr == AD_PAR_STAGE);

  assign sel_next  = wr_sel ? wr_data[SEL_BITS-1:0] : sel_stage;
  assign par_next  = wr_par ? wr_data[PAR_BITS-1:0] : par_stage;
  assign flag_next = wr_par ? wr_data[FLAG_BIT] : flag_stage;

  // commit only on the clear-to-set edge of the flag
  assign commit = wr_par && wr_data[FLAG_BIT] && !flag_stage;

  assign unused_pad = ^wr_data[FLAG_BIT-1:PAR_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_stage  <= '0;
      par_stage  <= '0;
      flag_stage <= 1'b0;
    end else begin
      sel_stage  <= sel_next;
      par_stage  <= par_next;
      flag_stage <= flag_next;
    end
  end

  p_flag_set_after_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> flag_stage);

  p_flag_tracks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_par |=> flag_stage == $past(wr_data[FLAG_BIT]));

  p_sel_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(sel_stage));

endmodule

// File: rtl/cdiv_strobe.sv
module cdiv_strobe
  import cdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic [DIV_W-1:0] ratio_o,
  output logic             strobe_o
);

  logic [DIV_W-1:0] ratio_q, cnt_q;
  logic             restart;

  assign restart  = commit_i && (ratio_i != ratio_q);
  assign strobe_o = strobe_due(cnt_q, ratio_q);
  assign ratio_o  = ratio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (commit_i) ratio_q <= ratio_i;
      if (restart || strobe_o) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  p_ratio_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(ratio_o));

  p_ratio_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> ratio_o == $past(ratio_i));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && ratio_q != '0 && !restart) |=> !strobe_o);

  p_phase_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ratio_q);

  p_full_first_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && ratio_i != '0) |=> !strobe_o);

endmodule

// File: rtl/cdiv_read_mux.sv
module cdiv_read_mux
  import cdiv_pkg::*;
(
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [SEL_BITS-1:0] sel_stage,
  input  logic [PAR_BITS-1:0] par_stage,
  input  logic                flag_stage,
  input  logic [SEL_BITS-1:0] sel_live,
  input  logic [PAR_BITS-1:0] par_live,
  output logic [REG_W-1:0]    rd_data
);

  always_comb begin
    unique case (cdiv_addr_e'(rd_addr))
      AD_SEL_STAGE: rd_data = pack_sel(sel_stage);
      AD_PAR_STAGE: rd_data = pack_par(par_stage, flag_stage);
      AD_SEL_LIVE:  rd_data = pack_sel(sel_live);
      default:      rd_data = pack_par(par_live, 1'b0);
    endcase
  end

endmodule

// File: rtl/cdiv_bank.sv
module cdiv_bank
  import cdiv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [REG_W-1:0]    rd_data,
  output logic [NUM_DIV-1:0]  div_strobe
);

  logic [SEL_BITS-1:0] sel_stage, sel_next, sel_live;
  logic [PAR_BITS-1:0] par_stage, par_next, par_live;
  logic                flag_stage, commit;

  cdiv_stage_regs u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sel_stage  (sel_stage),
    .par_stage  (par_stage),
    .flag_stage (flag_stage),
    .sel_next   (sel_next),
    .par_next   (par_next),
    .commit     (commit)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    for (genvar k = 0; k < DIV_PER_CH; k++) begin : g_div
      localparam int SLOT = slot_of(ch, k);
      logic [DIV_W-1:0] ratio_in, ratio_live;

      if (in_sel_word(k)) begin : g_sel
        assign ratio_in = sel_next[SLOT*DIV_W +: DIV_W];
        assign sel_live[SLOT*DIV_W +: DIV_W] = ratio_live;
      end else begin : g_par
        assign ratio_in = par_next[SLOT*DIV_W +: DIV_W];
        assign par_live[SLOT*DIV_W +: DIV_W] = ratio_live;
      end

      cdiv_strobe u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .ratio_i  (ratio_in),
        .ratio_o  (ratio_live),
        .strobe_o (div_strobe[ch*DIV_PER_CH + k])
      );
    end
  end

  cdiv_read_mux u_rd (
    .rd_addr    (rd_addr),
    .sel_stage  (sel_stage),
    .par_stage  (par_stage),
    .flag_stage (flag_stage),
    .sel_live   (sel_live),
    .par_live   (par_live),
    .rd_data    (rd_data)
  );

  p_live_only_on_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(sel_live) && $stable(par_live)));

  p_commit_copies_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (sel_live == sel_stage && par_live == par_stage));

  p_no_commit_while_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AD_PAR_STAGE && flag_stage) |=> ($stable(par_live) && $stable(sel_live)));

endmodule

// File: tb/cdiv_bank_bench.sv
module cdiv_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NDIV = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [13:0] div_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  logic [11:0] m_sel_stg = '0, m_sel_act = '0;
  logic [29:0] m_par_stg = '0, m_par_act = '0;
  bit          m_flag = 1'b0;
  int          age [NDIV];

  cdiv_bank u_cdiv_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .div_strobe (div_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bfield(int ch, int k, logic [11:0] s, logic [29:0] p);
    if (k < 2) return int'((s >> (6*ch + 3*k)) & 12'h7);
    return int'((p >> (15*ch + 3*(k-2))) & 30'h7);
  endfunction

  function automatic logic [31:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return {20'h0, m_sel_stg};
      2'd1: return {m_flag, 1'b0, m_par_stg};
      2'd2: return {20'h0, m_sel_act};
      default: return {2'b00, m_par_act};
    endcase
  endfunction

  function automatic logic [13:0] exp_strobes();
    logic [13:0] v;
    for (int d = 0; d < NDIV; d++) begin
      int n;
      n = bfield(d / 7, d % 7, m_sel_act, m_par_act);
      v[d] = ((age[d] % (n + 1)) == n);
    end
    return v;
  endfunction

  task automatic check32(string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic model_edge(bit we, logic [1:0] wa, logic [31:0] wd);
    logic [11:0] ns;
    logic [29:0] np;
    bit nf, com;
    ns = m_sel_stg; np = m_par_stg; nf = m_flag; com = 1'b0;
    if (we && wa == 2'd0) ns = wd[11:0];
    if (we && wa == 2'd1) begin
      np = wd[29:0];
      nf = wd[31];
      com = wd[31] && !m_flag;
    end
    for (int d = 0; d < NDIV; d++) begin
      if (com && bfield(d/7, d%7, ns, np) != bfield(d/7, d%7, m_sel_act, m_par_act))
        age[d] = 0;
      else
        age[d] = age[d] + 1;
    end
    if (com) begin
      m_sel_act = ns;
      m_par_act = np;
    end
    m_sel_stg = ns; m_par_stg = np; m_flag = nf;
  endtask

  // drive at falling edge, model at rising edge, compare at next falling edge
  task automatic tick(bit we, logic [1:0] wa, logic [31:0] wd, logic [1:0] ra);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(posedge clk);
    model_edge(we, wa, wd);
    @(negedge clk);
    wr_en = 1'b0;
    check32("strobes", {18'h0, div_strobe}, {18'h0, exp_strobes()});
    check32($sformatf("read addr %0d", ra), rd_data, exp_read(ra));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 2'd0, 32'h0, 2'(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < NDIV; d++) age[d] = 0;
    void'($urandom(32'h1c3d));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    tag = "R1";
    check32("strobes after reset", {18'h0, div_strobe}, 32'h3fff);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      check32($sformatf("reset read %0d", a), rd_data, 32'h0);
    end

    // R2 R3: layout and staged reads, unused bits zero
    tag = "R2 R3";
    tick(1'b1, 2'd0, 32'hffff_ffff, 2'd0);
    check32("R3 sel word", rd_data, 32'h0000_0fff);
    tick(1'b1, 2'd1, 32'h7fff_ffff, 2'd1);
    check32("R3 par word", rd_data, 32'h3fff_ffff);
    // R4: nothing committed yet
    tag = "R4";
    tick(1'b0, 2'd0, 32'h0, 2'd2);
    check32("R4 live sel untouched", rd_data, 32'h0);
    tick(1'b0, 2'd0, 32'h0, 2'd3);
    check32("R4 live par untouched", rd_data, 32'h0);

    // R5: commit carries same-write fields; main d2 = 5, aux d6 = 2
    tag = "R5 R8";
    tick(1'b1, 2'd0, 32'h0000_0a53, 2'd2);
    tick(1'b1, 2'd1, 32'h8000_0005 | (32'd2 << 27), 2'd3);
    check32("R5 live par", rd_data, 32'h1000_0005);
    tick(1'b0, 2'd0, 32'h0, 2'd2);
    check32("R5 live sel", rd_data, 32'h0000_0a53);
    idle(12);

    // R6: flag already set, no commit
    tag = "R6";
    tick(1'b1, 2'd1, 32'h8000_0007, 2'd3);
    check32("R6 live par unchanged", rd_data, 32'h1000_0005);
    idle(6);

    // R7: clearing the flag does not commit
    tag = "R7";
    tick(1'b1, 2'd1, 32'h0000_0001, 2'd3);
    check32("R7 live par unchanged", rd_data, 32'h1000_0005);
    tick(1'b0, 2'd0, 32'h0, 2'd1);
    check32("R7 flag clear", rd_data, 32'h0000_0001);

    // R10: main d0 from 3 to 6 restarts; strobe low 6 cycles then high
    tag = "R10 R9";
    tick(1'b1, 2'd0, 32'h0000_0a56, 2'd0);
    tick(1'b1, 2'd1, 32'h8000_0001, 2'd2);
    for (int i = 0; i < 6; i++) begin
      checks++;
      if (div_strobe[0] !== 1'b0) begin
        errors++;
        $display("FAIL R10 cycle %0d: actual=%b expected=0", i, div_strobe[0]);
      end
      tick(1'b0, 2'd0, 32'h0, 2'd2);
    end
    checks++;
    if (div_strobe[0] !== 1'b1) begin
      errors++;
      $display("FAIL R10 cycle 6: actual=%b expected=1", div_strobe[0]);
    end
    idle(20);

    // R11: recommit identical values keeps phase
    tag = "R11";
    tick(1'b1, 2'd1, 32'h0000_0001, 2'd1);
    idle(3);
    tick(1'b1, 2'd1, 32'h8000_0001, 2'd3);
    idle(15);

    // R12: writes to live addresses ignored
    tag = "R12";
    tick(1'b1, 2'd2, 32'hffff_ffff, 2'd2);
    tick(1'b1, 2'd3, 32'hffff_ffff, 2'd3);
    idle(4);

    // random mix
    tag = "R9 R4 R5";
    for (int i = 0; i < 4000; i++) begin
      bit we;
      logic [31:0] d;
      we = ($urandom % 3) == 0;
      d = $urandom;
      tick(we, 2'($urandom % 4), d, 2'($urandom % 4));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule